// File: doc/BRIEF.md
# Slow-Tick Timer with Alarm Compare

This block is a 32-bit up counter that advances once per slow real-time tick. A separate tick input, one clock wide, marks each tick. Each tick is compared against a programmable alarm value. When the counter reaches that value on a tick while alarms are enabled, the block raises a short-lived alarm flag. The flag drives three event outputs: an interrupt request, a wake-up, and a reset request. Each event output has its own route enable.

The block has two timebase modes. In the free-running mode the counter never stops and wraps from all-ones to zero. Software moves the alarm forward by adding an interval with modulo-2^32 arithmetic. In the auto-clear mode the hardware returns the counter to zero on every match, so the alarm value acts as a fixed interval. The only way to cancel a pending flag between ticks is to drop the alarm enable.

Alarms are programmed in three steps: clear the enable, write the alarm value, then set the enable again. The counter and the flag can be read back at any time.

Top module: `rtc_alarm_timer`

## Requirements
- R1: The counter adds one on each cycle where `tick` is high. It wraps from 0xFFFFFFFF to 0 without stopping. Without a tick or a write, it holds its value.
- R2: A counter write (`cnt_wr`) loads `cnt_wdata` on the next clock edge and takes priority over a tick in the same cycle. A loaded value never raises the alarm.
- R3: When alarms are enabled (`ctl_wdata[0]`=1) and a tick moves the counter onto the alarm value, `flag_o` rises on the same edge. In free-running mode (`ctl_wdata[1]`=0) the counter shows the alarm value and keeps counting on later ticks.
- R4: In auto-clear mode (`ctl_wdata[1]`=1) the matching tick leaves the counter at zero instead of the alarm value. Matches then repeat every N ticks, where N is the alarm value.
- R5: The flag lasts until the next tick at most. On a tick that is not a match it drops, and across tick-free cycles it holds.
- R6: While alarms are disabled, the flag never rises. After a control write that clears the enable, the flag is low two clock edges later.
- R7: A match fires only when a tick newly moves the counter onto the alarm value. Enabling alarms while the counter already equals the alarm value raises no event until the counter comes round again.
- R8: Each event output equals the flag ANDed with its own route bit: `irq_o` with `ctl_wdata[2]`, `wake_o` with `ctl_wdata[3]`, and `rst_req_o` with `ctl_wdata[4]`.
- R9: After reset, the counter, the alarm value, all control bits and the flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per slow timer tick |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 32 | Counter write value |
| alm_wr | input | 1 | Alarm value write strobe |
| alm_wdata | input | 32 | Alarm value write data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control bits: [0] enable, [1] auto-clear, [2] irq route, [3] wake route, [4] reset route |
| count_o | output | 32 | Counter readback |
| flag_o | output | 1 | Alarm event flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |
| rst_req_o | output | 1 | Reset request |

## Verification
The assertions check these rules on every cycle:
- a flag only rises on a tick;
- a flag only survives while alarms are enabled;
- the counter either advances by one or holds;
- on a match the counter lands on the alarm value (free-running mode) or on zero (auto-clear mode);
- no route fires without the flag.

Some behaviour needs history that only the bench's scenarios can build up:
- that a static equality does not retrigger after re-enabling;
- the exact auto-clear interval length;
- the wrap at all-ones;
- the write-over-tick priority.

These are checked against a behavioural model on every clock and with directed checks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CTL_W = 5;
  localparam int N_ROUTES = 3;

  // bit 0 enable, bit 1 auto-clear, bits 2..4 routes
  typedef struct packed {
    logic rst_route;
    logic wake_route;
    logic irq_route;
    logic autoclr;
    logic enable;
  } rtc_ctl_t;
endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  rtc_ctl_t         ctl_wdata,
  input  logic             alm_wr,
  input  logic [CNT_W-1:0] alm_wdata,
  output rtc_ctl_t         ctl_q,
  output logic [CNT_W-1:0] alm_q
);
  rtc_ctl_t         ctl_d;
  logic [CNT_W-1:0] alm_d;

  always_comb begin
    ctl_d = ctl_q;
    alm_d = alm_q;
    if (ctl_wr) ctl_d = ctl_wdata;
    if (alm_wr) alm_d = alm_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      alm_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      alm_q <= alm_d;
    end
  end
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_on_tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign cnt_ce  = load | tick;

  always_comb begin
    if (load)             cnt_d = load_val;
    else if (clr_on_tick) cnt_d = '0;
    else                  cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_match_unit.sv
module rtc_match_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic [CNT_W-1:0] alm_q,
  output logic             hit,
  output logic             flag_q
);
  logic flag_d;

  // equality is judged on the value the tick produces, so it only fires on arrival
  assign hit = tick & ~load & enable & (cnt_inc == alm_q);

  always_comb begin
    if (!enable)   flag_d = 1'b0;
    else if (tick) flag_d = hit;
    else           flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/rtc_event_router.sv
module rtc_event_router #(
  parameter int N_EV = 3
) (
  input  logic            flag,
  input  logic [N_EV-1:0] route_en,
  output logic [N_EV-1:0] ev
);
  for (genvar g = 0; g < N_EV; g++) begin : g_route
    assign ev[g] = flag & route_en[g];
  end
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             alm_wr,
  input  logic [CNT_W-1:0] alm_wdata,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wake_o,
  output logic             rst_req_o
);
  rtc_ctl_t            ctl_q;
  logic [CNT_W-1:0]    alm_q;
  logic [CNT_W-1:0]    cnt_inc;
  logic                hit;
  logic [N_ROUTES-1:0] ev;
  logic [N_ROUTES-1:0] route_en;

  rtc_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (rtc_ctl_t'(ctl_wdata)),
    .alm_wr    (alm_wr),
    .alm_wdata (alm_wdata),
    .ctl_q     (ctl_q),
    .alm_q     (alm_q)
  );

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .load        (cnt_wr),
    .load_val    (cnt_wdata),
    .clr_on_tick (hit & ctl_q.autoclr),
    .cnt_q       (count_o),
    .cnt_inc     (cnt_inc)
  );

  rtc_match_unit #(.CNT_W(CNT_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (cnt_wr),
    .enable  (ctl_q.enable),
    .cnt_inc (cnt_inc),
    .alm_q   (alm_q),
    .hit     (hit),
    .flag_q  (flag_o)
  );

  assign route_en = {ctl_q.rst_route, ctl_q.wake_route, ctl_q.irq_route};

  rtc_event_router #(.N_EV(N_ROUTES)) u_route (
    .flag     (flag_o),
    .route_en (route_en),
    .ev       (ev)
  );

  assign irq_o     = ev[0];
  assign wake_o    = ev[1];
  assign rst_req_o = ev[2];
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_wr,
  input logic             en,
  input logic             autoclr,
  input logic [CNT_W-1:0] alm_q,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             wake_o,
  input logic             rst_req_o
);
  // R1
  tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !autoclr) |=> count_o == $past(count_o) + 1'b1);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count_o));

  // R3
  free_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_o) && !$past(autoclr)) |-> count_o == $past(alm_q));

  // R4
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_o) && $past(autoclr)) |-> count_o == '0);

  // R5
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(tick));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !flag_o);

  // R8
  route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || wake_o || rst_req_o) |-> flag_o);
endmodule

bind rtc_alarm_timer rtc_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .cnt_wr    (cnt_wr),
  .en        (ctl_q.enable),
  .autoclr   (ctl_q.autoclr),
  .alm_q     (alm_q),
  .count_o   (count_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .wake_o    (wake_o),
  .rst_req_o (rst_req_o)
);

// File: tb/test_rtc_alarm_timer.sv
`timescale 1ns/1ps
module test_rtc_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [31:0] cnt_wdata = '0;
  logic        alm_wr = 1'b0;
  logic [31:0] alm_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [4:0]  ctl_wdata = '0;
  logic [31:0] count_o;
  logic        flag_o, irq_o, wake_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_timer i_rtc_alarm_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .alm_wr(alm_wr), .alm_wdata(alm_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .count_o(count_o), .flag_o(flag_o),
    .irq_o(irq_o), .wake_o(wake_o), .rst_req_o(rst_req_o)
  );

  // behavioural reference
  bit [31:0] m_cnt, m_alm;
  bit [4:0]  m_ctl;
  bit        m_flag;
  bit        m_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_alm = 0; m_ctl = 0; m_flag = 0;
    end else begin
      m_hit = tick && !cnt_wr && m_ctl[0] && (m_cnt + 32'd1 == m_alm);
      if (!m_ctl[0]) m_flag = 0;
      else if (tick) m_flag = m_hit;
      if (cnt_wr) m_cnt = cnt_wdata;
      else if (tick) m_cnt = (m_hit && m_ctl[1]) ? 32'd0 : m_cnt + 32'd1;
      if (alm_wr) m_alm = alm_wdata;
      if (ctl_wr) m_ctl = ctl_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 count vs model", count_o, m_cnt);
      chk("R3 flag vs model", {31'd0, flag_o}, {31'd0, m_flag});
      chk("R8 routes vs model", {29'd0, rst_req_o, wake_o, irq_o},
          {29'd0, m_flag & m_ctl[4], m_flag & m_ctl[3], m_flag & m_ctl[2]});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wcnt(input logic [31:0] v, input logic with_tick);
    cnt_wr = 1'b1; cnt_wdata = v; tick = with_tick;
    @(negedge clk);
    cnt_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic walm(input logic [31:0] v);
    alm_wr = 1'b1; alm_wdata = v; @(negedge clk); alm_wr = 1'b0;
  endtask

  task automatic wctl(input logic [4:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic program_alarm(input logic [31:0] a, input logic [4:0] c);
    wctl(5'b0); walm(a); wctl(c);
  endtask

  initial begin
    #300000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset state
    chk("R9 count after reset", count_o, 32'd0);
    chk("R9 flag after reset", {31'd0, flag_o}, 32'd0);

    // R1 counting and hold
    tk(3); idle(2);
    chk("R1 three ticks", count_o, 32'd3);
    wcnt(32'hFFFF_FFFE, 1'b0);
    tk(2);
    chk("R1 wrap to zero", count_o, 32'd0);

    // R2 write beats tick
    wcnt(32'h55, 1'b1);
    chk("R2 load over tick", count_o, 32'h55);

    // R3 free-running match
    program_alarm(32'd10, 5'b00101);
    wcnt(32'd7, 1'b0);
    tk(2);
    chk("R3 no flag before match", {31'd0, flag_o}, 32'd0);
    tk(1);
    chk("R3 flag on match", {31'd0, flag_o}, 32'd1);
    chk("R3 count holds alarm value", count_o, 32'd10);
    chk("R8 irq routed", {29'd0, rst_req_o, wake_o, irq_o}, 32'b001);
    idle(3);
    chk("R5 flag held without tick", {31'd0, flag_o}, 32'd1);
    tk(1);
    chk("R5 flag drops next tick", {31'd0, flag_o}, 32'd0);
    chk("R3 free-run continues", count_o, 32'd11);

    // R2 load equal to alarm raises nothing
    wcnt(32'd10, 1'b0); idle(1);
    chk("R2 load no event", {31'd0, flag_o}, 32'd0);

    // R6 disable clears flag
    program_alarm(32'd22, 5'b00001);
    wcnt(32'd20, 1'b0);
    tk(2);
    chk("R6 flag set before disable", {31'd0, flag_o}, 32'd1);
    wctl(5'b0); idle(1);
    chk("R6 flag cleared by disable", {31'd0, flag_o}, 32'd0);
    wcnt(32'd30, 1'b0); walm(32'd31); tk(1);
    chk("R6 disabled no flag", {31'd0, flag_o}, 32'd0);

    // R7 enable on equality: no retrigger
    wctl(5'b00001);
    tk(3);
    chk("R7 no retrigger", {31'd0, flag_o}, 32'd0);
    chk("R7 counter moved on", count_o, 32'd34);

    // R4 auto-clear interval
    program_alarm(32'd4, 5'b11011);
    wcnt(32'd0, 1'b0);
    tk(3);
    chk("R4 no early match", {31'd0, flag_o}, 32'd0);
    tk(1);
    chk("R4 match flag", {31'd0, flag_o}, 32'd1);
    chk("R4 counter cleared", count_o, 32'd0);
    chk("R8 wake and reset routed", {29'd0, rst_req_o, wake_o, irq_o}, 32'b110);
    tk(3);
    chk("R4 mid interval", count_o, 32'd3);
    tk(1);
    chk("R4 second match", {31'd0, flag_o}, 32'd1);

    // spaced ticks with model comparison
    for (int i = 0; i < 400; i++) begin
      tick = (i % 3 == 0);
      if (i == 150) program_alarm(32'd7, 5'b00111);
      @(negedge clk);
    end
    tick = 1'b0;
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule